// File: doc/BRIEF.md
# Sync-Referenced Programmable Pulse Generator

This block places two timing pulses on a video line, each relative to a one-cycle strobe that marks a detected falling edge of horizontal sync. It counts pixel clocks from that strobe and shapes two outputs from the count. The first is an outgoing horizontal drive pulse. It starts one clock after the strobe, and its end is programmable. The second is an internal clamp pulse that gates the DC-restore input of the video A/D converter. Its start is programmable and it lasts a fixed number of clocks.

Each offset is a 10-bit clock count, written through a byte-wide register port. The low eight bits and the top two bits sit at separate addresses. Software writes go into shadow registers. The block copies them into its working set only at a sync strobe, so a line already in progress keeps its timing. Sync detection, line locking and the converter itself are outside the block.

Top module: `sync_pulse_gen`

## Requirements
- R1: After reset, reads return 20h at address 0Eh, 00h at 0Fh, 37h at 12h and 00h at 13h.
- R2: Address 0Eh holds drive-end bits 7:0 and 0Fh holds its bits 9:8 in data bits 1:0. Address 12h holds clamp-start bits 7:0 and 13h holds its bits 9:8 in data bits 1:0. A write lands on the clock edge where reg_wr_en is high. reg_rdata shows the addressed value combinationally.
- R3: At 0Fh and 13h, data bits 7:2 ignore writes and read as zero. At every other address, writes change nothing and reads return zero.
- R4: From reset until the first sync strobe is sampled, drive_pulse and clamp_pulse stay low.
- R5: When sync_fall is sampled high on an edge, drive_pulse is high for the next E+1 cycles and then low. E is the latched 10-bit drive-end value.
- R6: Let S be the latched 10-bit clamp-start value. Count the cycle right after the strobe edge as cycle 0. clamp_pulse is high from cycle S through cycle S+15, which is 16 cycles, and low otherwise.
- R7: Register writes affect the pulses only from the next sync strobe on. A write on the same edge as a strobe applies to the strobe after it.
- R8: A sync strobe restarts both pulse timings from cycle 0, even while a pulse is still active.
- R9: With no further strobe, both outputs stay low after their pulses end, however long the line lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_fall | input | 1 | One-cycle strobe at a detected hsync falling edge |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| drive_pulse | output | 1 | Horizontal drive pulse |
| clamp_pulse | output | 1 | DC-restore clamp pulse to the A/D converter |

## Verification
The assertions assume that sync_fall behaves as an edge strobe. It stays high for single cycles only, so no pulse is held high by a strobe repeating on every clock. They also assume the register address is stable whenever reg_rdata is sampled. The stimulus always issues sync_fall as a single-cycle pulse between gaps of at least one idle cycle. It changes address and data only at the falling clock edge. Random gaps run up to about 1300 clocks, so they cover both strobes that cut a pulse short and lines much longer than any programmed offset.

// File: rtl/hpg_pkg.sv
package hpg_pkg;

    localparam int OFS_W = 10;
    localparam int NCH   = 2;
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CH_DRV = 0;
    localparam int CH_CLP = 1;

    typedef logic [7:0]       byte_t;
    typedef logic [OFS_W-1:0] ofs_t;
    typedef logic [NCH-1:0][OFS_W-1:0] cfg_t;

    typedef enum logic {LANE_LO = 1'b0, LANE_HI = 1'b1} lane_e;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
        lane_e           lane;
    } reg_sel_t;

    localparam byte_t LO_ADDR [NCH] = '{8'h0E, 8'h12};
    localparam byte_t HI_ADDR [NCH] = '{8'h0F, 8'h13};
    localparam ofs_t  RST_VAL [NCH] = '{10'h020, 10'h037};

    function automatic reg_sel_t decode_addr(byte_t a);
        reg_sel_t s;
        s = '{hit: 1'b0, ch: '0, lane: LANE_LO};
        for (int i = 0; i < NCH; i++) begin
            if (a == LO_ADDR[i]) s = '{hit: 1'b1, ch: CH_W'(i), lane: LANE_LO};
            if (a == HI_ADDR[i]) s = '{hit: 1'b1, ch: CH_W'(i), lane: LANE_HI};
        end
        return s;
    endfunction

    function automatic byte_t read_lane(ofs_t v, lane_e l);
        return (l == LANE_LO) ? v[7:0] : byte_t'(v >> 8);
    endfunction

endpackage

// File: rtl/hpg_regs.sv
module hpg_regs
    import hpg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t addr,
    input  byte_t wdata,
    output byte_t rdata,
    output cfg_t  cfg
);

    reg_sel_t sel;
    assign sel = decode_addr(addr);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g] <= RST_VAL[g];
            end else if (wr_en && sel.hit && (sel.ch == CH_W'(g))) begin
                if (sel.lane == LANE_LO)
                    cfg[g][7:0] <= wdata;
                else
                    cfg[g][OFS_W-1:8] <= wdata[OFS_W-9:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel.hit) rdata = read_lane(cfg[sel.ch], sel.lane);
    end

endmodule

// File: rtl/hpg_line_timer.sv
module hpg_line_timer
    import hpg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_fall,
    input  cfg_t             cfg_in,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output cfg_t             cfg_lat
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            cnt     <= '0;
            cfg_lat <= '0;
        end else if (sync_fall) begin
            run     <= 1'b1;
            cnt     <= '0;
            cfg_lat <= cfg_in;
        end else if (run && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hpg_pulse_shape.sv
module hpg_pulse_shape
    import hpg_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int CLAMP_LEN = 16
) (
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  cfg_t             cfg_lat,
    output logic             drive,
    output logic             clamp
);

    logic [CNT_W-1:0] end_c;
    assign end_c = CNT_W'(cfg_lat[CH_DRV]);
    assign drive = run && (cnt <= end_c);

    if (CLAMP_LEN == 0) begin : g_no_clamp
        assign clamp = 1'b0;
    end else begin : g_clamp
        logic [CNT_W-1:0] st_c, st_lim;
        assign st_c   = CNT_W'(cfg_lat[CH_CLP]);
        assign st_lim = st_c + CNT_W'(CLAMP_LEN);
        assign clamp  = run && (cnt >= st_c) && (cnt < st_lim);
    end

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
    import hpg_pkg::*;
#(
    parameter int CLAMP_LEN = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_fall,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       drive_pulse,
    output logic       clamp_pulse
);

    localparam int CNT_W = $clog2((1 << OFS_W) + CLAMP_LEN) + 1;

    cfg_t             cfg_shadow;
    cfg_t             cfg_work;
    logic             line_run;
    logic [CNT_W-1:0] line_cnt;

    hpg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg_shadow)
    );

    hpg_line_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .sync_fall (sync_fall),
        .cfg_in    (cfg_shadow),
        .run       (line_run),
        .cnt       (line_cnt),
        .cfg_lat   (cfg_work)
    );

    hpg_pulse_shape #(.CNT_W(CNT_W), .CLAMP_LEN(CLAMP_LEN)) u_shape (
        .run     (line_run),
        .cnt     (line_cnt),
        .cfg_lat (cfg_work),
        .drive   (drive_pulse),
        .clamp   (clamp_pulse)
    );

endmodule

// File: rtl/hpg_checker.sv
module hpg_checker
    import hpg_pkg::*;
#(
    parameter int LEN = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       sync_fall,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic       drive_pulse,
    input logic       clamp_pulse
);

    localparam int RUN_W = $clog2(LEN + 2) + 1;

    logic             seen_sync;
    logic [RUN_W-1:0] clamp_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_sync <= 1'b0;
            clamp_run <= '0;
        end else begin
            if (sync_fall) seen_sync <= 1'b1;
            if (sync_fall || !clamp_pulse)
                clamp_run <= '0;
            else if (clamp_run != '1)
                clamp_run <= clamp_run + 1'b1;
        end
    end

    a_r3_hi_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ((reg_addr == HI_ADDR[CH_DRV]) || (reg_addr == HI_ADDR[CH_CLP]))
            |-> ((reg_rdata >> (OFS_W - 8)) == '0));

    a_r4_quiet_before_sync: assert property (@(posedge clk) disable iff (rst)
        !seen_sync |-> (!drive_pulse && !clamp_pulse));

    a_r5_drive_follows_sync: assert property (@(posedge clk) disable iff (rst)
        sync_fall |=> drive_pulse);

    a_r5_drive_rise_src: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_pulse) |-> $past(sync_fall));

    a_r6_clamp_len_max: assert property (@(posedge clk) disable iff (rst)
        clamp_run <= RUN_W'(LEN));

endmodule

bind sync_pulse_gen hpg_checker #(.LEN(CLAMP_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_fall   (sync_fall),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .drive_pulse (drive_pulse),
    .clamp_pulse (clamp_pulse)
);

// File: tb/sync_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module sync_pulse_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_fall = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       drive_pulse;
    logic       clamp_pulse;

    always #2.5 clk = ~clk;

    sync_pulse_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .sync_fall   (sync_fall),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .drive_pulse (drive_pulse),
        .clamp_pulse (clamp_pulse)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state built from the requirements
    int sh_end, sh_st, lat_end, lat_st, k;
    string tag_d, tag_c;

    function automatic bit exp_drive();
        return (k >= 0) && (k <= lat_end);
    endfunction

    function automatic bit exp_clamp();
        return (k >= 0) && (k >= lat_st) && (k < lat_st + 16);
    endfunction

    function automatic int exp_rd(int a);
        case (a)
            8'h0E:   return sh_end & 8'hFF;
            8'h0F:   return sh_end >> 8;
            8'h12:   return sh_st & 8'hFF;
            8'h13:   return sh_st >> 8;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(bit s, bit w, int a, int d, string rtag);
        @(negedge clk);
        chk(tag_d, "drive_pulse", int'(drive_pulse), int'(exp_drive()));
        chk(tag_c, "clamp_pulse", int'(clamp_pulse), int'(exp_clamp()));
        sync_fall = s;
        reg_wr_en = w;
        reg_addr  = 8'(a);
        reg_wdata = 8'(d);
        #1;
        chk(rtag, "reg_rdata", int'(reg_rdata), exp_rd(a));
        if (s) begin
            lat_end = sh_end;
            lat_st  = sh_st;
            k = 0;
        end else if (k >= 0 && k < 4095) begin
            k++;
        end
        if (w) begin
            case (a)
                8'h0E: sh_end = (sh_end & 'h300) | (d & 'hFF);
                8'h0F: sh_end = (sh_end & 'hFF) | ((d & 3) << 8);
                8'h12: sh_st  = (sh_st & 'h300) | (d & 'hFF);
                8'h13: sh_st  = (sh_st & 'hFF) | ((d & 3) << 8);
                default: ;
            endcase
        end
    endtask

    task automatic idle(int n, string rtag);
        for (int i = 0; i < n; i++) step(0, 0, 8'h0E, 0, rtag);
    endtask

    function automatic int pick_addr();
        int r;
        r = int'($urandom % 5);
        case (r)
            0: return 8'h0E;
            1: return 8'h0F;
            2: return 8'h12;
            3: return 8'h13;
            default: return int'($urandom % 256);
        endcase
    endfunction

    initial begin
        #(5ns * 150000);
        if (!done) begin
            bad++;
            $display("FAIL all watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        sh_end = 'h020; sh_st = 'h037; lat_end = 0; lat_st = 0; k = -1;
        tag_d = "R4"; tag_c = "R4";
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        step(0, 0, 8'h0E, 0, "R1");
        step(0, 0, 8'h0F, 0, "R1");
        step(0, 0, 8'h12, 0, "R1");
        step(0, 0, 8'h13, 0, "R1");
        // R4: quiet before any strobe
        idle(40, "R4");

        // R3: upper bits and unmapped addresses
        step(0, 1, 8'h0F, 8'hFD, "R3");
        step(0, 0, 8'h0F, 0, "R3");
        step(0, 1, 8'h20, 8'h5A, "R3");
        step(0, 0, 8'h20, 0, "R3");
        step(0, 1, 8'h13, 8'hFE, "R3");
        step(0, 0, 8'h13, 0, "R3");
        // R2: program end=8, start=3
        step(0, 1, 8'h0F, 8'h00, "R2");
        step(0, 1, 8'h0E, 8'h08, "R2");
        step(0, 1, 8'h13, 8'h00, "R2");
        step(0, 1, 8'h12, 8'h03, "R2");
        step(0, 0, 8'h0E, 0, "R2");
        step(0, 0, 8'h12, 0, "R2");
        idle(10, "R4");

        // R5 / R6: basic line
        tag_d = "R5"; tag_c = "R6";
        step(1, 0, 8'h0E, 0, "R2");
        idle(40, "R2");

        // R7: write mid-pulse, and write on strobe edge
        tag_d = "R7"; tag_c = "R7";
        step(1, 0, 8'h0E, 0, "R2");
        idle(2, "R2");
        step(0, 1, 8'h0E, 8'h10, "R7");
        step(0, 1, 8'h12, 8'h06, "R7");
        idle(40, "R7");
        step(1, 1, 8'h0E, 8'h02, "R7");
        idle(40, "R7");
        step(1, 0, 8'h0E, 0, "R7");
        idle(40, "R7");

        // R8: restart mid-pulse
        tag_d = "R8"; tag_c = "R8";
        step(0, 1, 8'h0E, 8'h20, "R8");
        step(1, 0, 8'h0E, 0, "R8");
        idle(5, "R8");
        step(1, 0, 8'h0E, 0, "R8");
        idle(12, "R8");
        step(1, 0, 8'h0E, 0, "R8");
        idle(40, "R8");

        // R9: long line, counter saturation
        tag_d = "R9"; tag_c = "R9";
        step(1, 0, 8'h0E, 0, "R9");
        idle(4300, "R9");

        // random lines
        tag_d = "R5"; tag_c = "R6";
        for (int r = 0; r < 60; r++) begin
            for (int j = 0; j < 4; j++)
                step(0, 1, pick_addr(), int'($urandom % 256), "R2");
            step(1, 0, pick_addr(), 0, "R3");
            for (int g = 0; g < 1 + int'($urandom % 1300); g++) begin
                bit w;
                w = ($urandom % 40) == 0;
                step(0, w, pick_addr(), int'($urandom % 256), "R2");
            end
        end
        step(0, 0, 8'h0E, 0, "R2");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule